// File: doc/BRIEF.md
# Four-Edge Handshake Word Synchronizer

This block carries a multi-bit word from a source clock domain into a destination clock domain that has no fixed phase or frequency relationship to it. The source captures the word into a holding register and raises a request level. The destination synchronizes that level, takes the word once, and raises an acknowledge level. The acknowledge is synchronized back to the source, which then lowers the request. The destination lowers the acknowledge when it sees the request go low.

Only the two control levels cross the boundary, and each passes through a chain of flip-flops clocked by the receiving domain. The word itself is never synchronized. It is held stable from before the request rises until the handshake has fully closed, so the destination always samples settled bits. One transfer costs two complete synchronizer round trips. The block is suited to configuration words, counter snapshots and other low-rate values, not to streaming data.

On the source side the user presents a word with a one-cycle send strobe and watches the busy output. On the destination side a one-cycle valid pulse marks each word that arrives.

Top module: `cdc_word_handshake`

## Requirements
- R1: Each control level reaches the other domain only through a chain of SYNC_STAGES (default 2) flip-flops clocked and reset by the receiving domain. A word is therefore never delivered in the same destination cycle in which it was sent.
- R2: The request level stays high from the moment it rises until the source has seen the synchronized acknowledge high. It falls only after that point.
- R3: The source holding register does not change while busy is high.
- R4: The control edges occur in a fixed order: request rises, then acknowledge rises, then request falls, then acknowledge falls. Request rises only while the synchronized acknowledge is low. Acknowledge falls only after the synchronized request is low.
- R5: The destination captures the word only in the cycle where its synchronized request is first seen high. The valid output is then high for exactly one destination cycle, and the data output already carries the sent word in that cycle. The data output changes only together with valid.
- R6: A send strobe that arrives while busy is high is ignored. It does not change the word that is delivered, and it does not start another transfer.
- R7: Busy rises in the source cycle after an accepted send strobe. Busy falls only after the synchronized acknowledge has returned low, and by then the word has already been delivered.
- R8: The active-high synchronous resets, one per domain, return request, acknowledge, busy, valid and both FSMs to idle, and clear the data output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source domain clock |
| srcRst | input | 1 | Source domain synchronous reset, active high |
| srcDataIn | input | DATA_W | Word to transfer, sampled with an accepted send |
| srcSend | input | 1 | One-cycle send strobe |
| srcBusy | output | 1 | High while a transfer is in progress |
| dstClk | input | 1 | Destination domain clock |
| dstRst | input | 1 | Destination domain synchronous reset, active high |
| dstDataOut | output | DATA_W | Last word received |
| dstValid | output | 1 | One-cycle pulse when a new word arrives |

## Verification
The bench sends every possible value of an 8-bit word, one after another. This exposes a bit that is dropped, stuck or swapped, and an arriving word that is stale. On alternate words it fires an extra send strobe carrying the inverted word while busy is high. A design that lets the source register be overwritten, or that starts a second transfer, then delivers the wrong word or an extra valid pulse. The bench then applies a reset in the middle of a transfer to show that both sides return to idle and can carry a fresh word. The two clocks have unrelated periods, so the phase of request and acknowledge shifts from one transfer to the next.

// File: rtl/cdc_hs_pkg.sv
package cdc_hs_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE,
    SRC_WAIT_ACK_HI,
    SRC_WAIT_ACK_LO
  } srcState_t;

  typedef enum logic {
    DST_IDLE,
    DST_WAIT_REQ_LO
  } dstState_t;

  // Source-domain strobes from control to datapath
  typedef struct packed {
    logic loadWord;
    logic raiseReq;
    logic dropReq;
  } srcStrobe_t;

  // Destination-domain strobes from control to datapath
  typedef struct packed {
    logic captureWord;
    logic raiseAck;
    logic dropAck;
  } dstStrobe_t;

endpackage

// File: rtl/cdc_hs_sync.sv
module cdc_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cdc_hs_ctrl.sv
module cdc_hs_ctrl
  import cdc_hs_pkg::*;
(
  input  logic       srcClk,
  input  logic       srcRst,
  input  logic       srcSend,
  input  logic       ackSeen,
  output srcStrobe_t srcStrobe,
  output logic       srcBusy,
  input  logic       dstClk,
  input  logic       dstRst,
  input  logic       reqSeen,
  output dstStrobe_t dstStrobe
);
  srcState_t srcState, srcNext;
  dstState_t dstState, dstNext;

  // Source FSM
  always_comb begin
    srcNext   = srcState;
    srcStrobe = '0;
    case (srcState)
      SRC_IDLE: begin
        if (srcSend) begin
          srcStrobe.loadWord = 1'b1;
          srcStrobe.raiseReq = 1'b1;
          srcNext            = SRC_WAIT_ACK_HI;
        end
      end
      SRC_WAIT_ACK_HI: begin
        if (ackSeen) begin
          srcStrobe.dropReq = 1'b1;
          srcNext           = SRC_WAIT_ACK_LO;
        end
      end
      SRC_WAIT_ACK_LO: begin
        if (!ackSeen) srcNext = SRC_IDLE;
      end
      default: srcNext = SRC_IDLE;
    endcase
  end

  always_ff @(posedge srcClk) begin
    if (srcRst) srcState <= SRC_IDLE;
    else        srcState <= srcNext;
  end

  assign srcBusy = (srcState != SRC_IDLE);

  // Destination FSM
  always_comb begin
    dstNext   = dstState;
    dstStrobe = '0;
    case (dstState)
      DST_IDLE: begin
        if (reqSeen) begin
          dstStrobe.captureWord = 1'b1;
          dstStrobe.raiseAck    = 1'b1;
          dstNext               = DST_WAIT_REQ_LO;
        end
      end
      DST_WAIT_REQ_LO: begin
        if (!reqSeen) begin
          dstStrobe.dropAck = 1'b1;
          dstNext           = DST_IDLE;
        end
      end
      default: dstNext = DST_IDLE;
    endcase
  end

  always_ff @(posedge dstClk) begin
    if (dstRst) dstState <= DST_IDLE;
    else        dstState <= dstNext;
  end
endmodule

// File: rtl/cdc_hs_datapath.sv
module cdc_hs_datapath
  import cdc_hs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              srcClk,
  input  logic              srcRst,
  input  logic [DATA_W-1:0] srcDataIn,
  input  srcStrobe_t        srcStrobe,
  output logic [DATA_W-1:0] srcWord,
  output logic              reqLevel,
  output logic              ackSeen,
  input  logic              dstClk,
  input  logic              dstRst,
  input  dstStrobe_t        dstStrobe,
  output logic              ackLevel,
  output logic              reqSeen,
  output logic [DATA_W-1:0] dstDataOut,
  output logic              dstValid
);
  // Source holding register and request level
  always_ff @(posedge srcClk) begin
    if (srcRst) begin
      srcWord  <= '0;
      reqLevel <= 1'b0;
    end else begin
      if (srcStrobe.loadWord) srcWord <= srcDataIn;
      if (srcStrobe.raiseReq)     reqLevel <= 1'b1;
      else if (srcStrobe.dropReq) reqLevel <= 1'b0;
    end
  end

  // Destination capture register, acknowledge level, valid pulse
  always_ff @(posedge dstClk) begin
    if (dstRst) begin
      dstDataOut <= '0;
      ackLevel   <= 1'b0;
      dstValid   <= 1'b0;
    end else begin
      if (dstStrobe.captureWord) dstDataOut <= srcWord;
      if (dstStrobe.raiseAck)     ackLevel <= 1'b1;
      else if (dstStrobe.dropAck) ackLevel <= 1'b0;
      dstValid <= dstStrobe.captureWord;
    end
  end

  cdc_hs_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk (dstClk),
    .rst (dstRst),
    .din (reqLevel),
    .dout(reqSeen)
  );

  cdc_hs_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk (srcClk),
    .rst (srcRst),
    .din (ackLevel),
    .dout(ackSeen)
  );
endmodule

// File: rtl/cdc_word_handshake.sv
module cdc_word_handshake
  import cdc_hs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              srcClk,
  input  logic              srcRst,
  input  logic [DATA_W-1:0] srcDataIn,
  input  logic              srcSend,
  output logic              srcBusy,
  input  logic              dstClk,
  input  logic              dstRst,
  output logic [DATA_W-1:0] dstDataOut,
  output logic              dstValid
);
  srcStrobe_t        srcStrobe;
  dstStrobe_t        dstStrobe;
  logic [DATA_W-1:0] srcWord;
  logic              reqLevel;
  logic              reqSeen;
  logic              ackLevel;
  logic              ackSeen;

  cdc_hs_ctrl u_ctrl (
    .srcClk   (srcClk),
    .srcRst   (srcRst),
    .srcSend  (srcSend),
    .ackSeen  (ackSeen),
    .srcStrobe(srcStrobe),
    .srcBusy  (srcBusy),
    .dstClk   (dstClk),
    .dstRst   (dstRst),
    .reqSeen  (reqSeen),
    .dstStrobe(dstStrobe)
  );

  cdc_hs_datapath #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .srcClk    (srcClk),
    .srcRst    (srcRst),
    .srcDataIn (srcDataIn),
    .srcStrobe (srcStrobe),
    .srcWord   (srcWord),
    .reqLevel  (reqLevel),
    .ackSeen   (ackSeen),
    .dstClk    (dstClk),
    .dstRst    (dstRst),
    .dstStrobe (dstStrobe),
    .ackLevel  (ackLevel),
    .reqSeen   (reqSeen),
    .dstDataOut(dstDataOut),
    .dstValid  (dstValid)
  );
endmodule

// File: rtl/cdc_hs_checks.sv
module cdc_hs_checks #(
  parameter int DATA_W = 8
) (
  input logic              srcClk,
  input logic              srcRst,
  input logic              srcBusy,
  input logic [DATA_W-1:0] srcWord,
  input logic              reqLevel,
  input logic              ackSeen,
  input logic              dstClk,
  input logic              dstRst,
  input logic              ackLevel,
  input logic              reqSeen,
  input logic              dstValid,
  input logic [DATA_W-1:0] dstDataOut
);
  // R1: a synchronized level can only rise after the driven level was high
  p_req_sync_r1: assert property (@(posedge dstClk) disable iff (dstRst)
    $rose(reqSeen) |-> $past(reqLevel));
  p_ack_sync_r1: assert property (@(posedge srcClk) disable iff (srcRst)
    $rose(ackSeen) |-> $past(ackLevel));

  // R2: request held until acknowledge seen
  p_req_hold_r2: assert property (@(posedge srcClk) disable iff (srcRst)
    (reqLevel && !ackSeen) |=> reqLevel);
  p_req_fall_r2: assert property (@(posedge srcClk) disable iff (srcRst)
    $fell(reqLevel) |-> $past(ackSeen));

  // R3: holding register frozen while busy
  p_word_stable_r3: assert property (@(posedge srcClk) disable iff (srcRst)
    ($past(srcBusy) && srcBusy) |-> $stable(srcWord));

  // R4: edge ordering
  p_req_rise_r4: assert property (@(posedge srcClk) disable iff (srcRst)
    $rose(reqLevel) |-> !$past(ackSeen));
  p_ack_rise_r4: assert property (@(posedge dstClk) disable iff (dstRst)
    $rose(ackLevel) |-> $past(reqSeen));
  p_ack_fall_r4: assert property (@(posedge dstClk) disable iff (dstRst)
    $fell(ackLevel) |-> !$past(reqSeen));

  // R5: single-cycle valid, data only moves with valid
  p_valid_width_r5: assert property (@(posedge dstClk) disable iff (dstRst)
    dstValid |=> !dstValid);
  p_data_with_valid_r5: assert property (@(posedge dstClk) disable iff (dstRst)
    !$stable(dstDataOut) |-> dstValid);

  // R7: busy drops only after acknowledge returned low
  p_busy_drop_r7: assert property (@(posedge srcClk) disable iff (srcRst)
    $fell(srcBusy) |-> (!$past(ackSeen) && !reqLevel));
endmodule

bind cdc_word_handshake cdc_hs_checks #(.DATA_W(DATA_W)) u_checks (
  .srcClk    (srcClk),
  .srcRst    (srcRst),
  .srcBusy   (srcBusy),
  .srcWord   (srcWord),
  .reqLevel  (reqLevel),
  .ackSeen   (ackSeen),
  .dstClk    (dstClk),
  .dstRst    (dstRst),
  .ackLevel  (ackLevel),
  .reqSeen   (reqSeen),
  .dstValid  (dstValid),
  .dstDataOut(dstDataOut)
);

// File: tb/tb_cdc_word_handshake.sv
module tb_cdc_word_handshake;
  localparam int DATA_W = 8;

  logic              srcClk = 1'b0;
  logic              dstClk = 1'b0;
  logic              srcRst = 1'b1;
  logic              dstRst = 1'b1;
  logic [DATA_W-1:0] srcDataIn = '0;
  logic              srcSend = 1'b0;
  logic              srcBusy;
  logic [DATA_W-1:0] dstDataOut;
  logic              dstValid;

  int checks = 0;
  int errors = 0;
  int sentCount = 0;
  int recvCount = 0;
  logic [DATA_W-1:0] expWord = '0;
  bit monOn = 1'b0;
  bit prevValid = 1'b0;
  bit done = 1'b0;

  always #10 srcClk = ~srcClk;   // 50 MHz source clock
  always #8  dstClk = ~dstClk;   // unrelated destination clock

  cdc_word_handshake #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
    .srcClk    (srcClk),
    .srcRst    (srcRst),
    .srcDataIn (srcDataIn),
    .srcSend   (srcSend),
    .srcBusy   (srcBusy),
    .dstClk    (dstClk),
    .dstRst    (dstRst),
    .dstDataOut(dstDataOut),
    .dstValid  (dstValid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Destination monitor
  always @(negedge dstClk) begin
    if (monOn) begin
      if (dstValid) begin
        check(dstDataOut == expWord, "R5 delivered word", dstDataOut, expWord);
        check(!prevValid, "R5 valid one cycle wide", prevValid, 0);
        recvCount++;
      end
    end
    prevValid = dstValid;
  end

  task automatic sendWord(input logic [DATA_W-1:0] w, input bit inject);
    @(negedge srcClk);
    srcDataIn = w;
    srcSend   = 1'b1;
    expWord   = w;
    @(negedge srcClk);
    srcSend = 1'b0;
    sentCount++;
    check(srcBusy == 1'b1, "R7 busy after send", srcBusy, 1);
    check(recvCount == sentCount - 1, "R1 not delivered at once", recvCount, sentCount - 1);
    if (inject) begin
      repeat (3) @(negedge srcClk);
      srcDataIn = ~w;
      srcSend   = 1'b1;
      @(negedge srcClk);
      srcSend = 1'b0;
    end
    while (srcBusy) @(negedge srcClk);
    check(recvCount == sentCount, "R7 word delivered before busy low", recvCount, sentCount);
    if (inject) begin
      repeat (12) @(negedge srcClk);
      check(srcBusy == 1'b0, "R6 no restart from ignored send", srcBusy, 0);
      check(recvCount == sentCount, "R6 no extra transfer", recvCount, sentCount);
    end
  endtask

  initial begin
    repeat (4) @(negedge srcClk);
    srcRst = 1'b0;
    dstRst = 1'b0;
    @(negedge srcClk);
    check(srcBusy == 1'b0, "R8 busy at reset", srcBusy, 0);
    check(dstValid == 1'b0, "R8 valid at reset", dstValid, 0);
    check(dstDataOut == '0, "R8 data at reset", dstDataOut, 0);
    monOn = 1'b1;

    // Sweep every word; inject an ignored strobe on odd words (R6)
    for (int i = 0; i < (1 << DATA_W); i++) begin
      sendWord(i[DATA_W-1:0], i[0]);
    end

    // Reset in the middle of a transfer (R8)
    @(negedge srcClk);
    srcDataIn = 8'hA5;
    srcSend   = 1'b1;
    @(negedge srcClk);
    srcSend = 1'b0;
    monOn   = 1'b0;
    @(negedge srcClk);
    srcRst = 1'b1;
    dstRst = 1'b1;
    repeat (4) @(negedge srcClk);
    srcRst = 1'b0;
    dstRst = 1'b0;
    @(negedge srcClk);
    check(srcBusy == 1'b0, "R8 busy after mid reset", srcBusy, 0);
    check(dstValid == 1'b0, "R8 valid after mid reset", dstValid, 0);
    check(dstDataOut == '0, "R8 data after mid reset", dstDataOut, 0);
    repeat (4) @(negedge srcClk);
    check(srcBusy == 1'b0, "R8 stays idle", srcBusy, 0);
    sentCount = 0;
    recvCount = 0;
    monOn = 1'b1;
    sendWord(8'h3C, 1'b0);
    check(dstDataOut == 8'h3C, "R5 word after reset", dstDataOut, 8'h3C);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge srcClk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule